// File: doc/BRIEF.md
# Region-Attribute Write Policy Engine

This block sits between a CPU load/store pipeline and the cache and bus. Every access arrives with an 8-bit region attribute byte and a cache-hit flag. The block works out what the access does to the cache: serve a read hit, fill on a read miss, read from the bus, update the line, mark it dirty or allocate it. It also decides whether and how the access reaches the bus as a write. Uncached writes leave one at a time in program order. Writes to combining regions collect in a one-line buffer, where the last write to a byte wins. Writes to serialized regions are held back while the number of bus writes in flight is at a programmable cap.

The CPU request port and the bus write port are valid/ready. On the request port, `req_ready` is worked out from the payload offered in the same cycle, so it can change with that payload. A request is accepted on any rising edge where `req_valid` and `req_ready` are both high. On the bus write port, once `bw_valid` is high it stays high, with its payload unchanged, until a rising edge where `bw_ready` is also high. Only one bus write is ever held at a time. The cache decision for an accepted request appears on the `act_*` outputs one cycle after acceptance, qualified by `act_valid`. Bus write completions come back as pulses on `bw_done`.

Attribute bits: bit 0 cache-disable (CD), bit 1 write-allocate (WA), bit 2 write-protect (WP), bit 3 write-through (WT), bit 4 write-combine (WC), bit 5 write-serialize (WS). Bits 7:6 are reserved and ignored.

Top module: `rgn_policy_engine`

## Requirements
- R1: A read hit gives `act_rd_hit` = 1 with no fill and no bus read, whether CD is 0 or 1. Attribute bits 7:6 have no effect on any decision.
- R2: On a read miss, CD = 0 gives `act_fill` = 1, and CD = 1 gives `act_bus_rd` = 1.
- R3: These accesses are undefined: a read with WS = 1 and CD = 0, and a write with WP = 0 that has (WS or WC) with CD = 0, or WA with CD = 1. An undefined access produces no cache action and no bus write, and it sets `err_flag`. The flag stays set until an `err_clr` pulse. If a new error and `err_clr` arrive in the same cycle, the new error wins.
- R4: A write with WP = 1 is discarded: no cache action, no bus write and no error.
- R5: With CD = WT = WC = WS = 0 (write-back), a write hit gives update plus dirty. A write miss gives allocate when WA = 1, and a bus write otherwise.
- R6: With CD = 0 and WT = 1, a hit gives update without dirty, a miss never allocates, and every write becomes a bus write.
- R7: With CD = 1 and WC = 0, a write hit also gives update. Each write becomes one bus write, issued in acceptance order. `bw_line` = address[31:5], the data sits at byte lane address[4:2]×4 + i, and `bw_be` holds `req_be` at that position.
- R8: With CD = 1, WS = 1 and WC = 0, a write is accepted only while the outstanding bus-write count is below `ws_limit`, where a value of 0 counts as 1. The count rises on each bus handshake and falls on each `bw_done`.
- R9: With CD = 1 and WC = 1, a write only merges into the combine buffer. A later write to a byte overwrites the earlier one. The buffer leaves as one masked bus write with one `bw_be` bit per valid byte.
- R10: The combine buffer is flushed before any other request is accepted: a write to a different line, a non-combining access or any read. It is also flushed after a `flush_in` pulse. In each case the flush write precedes the bus write of the triggering request.
- R11: `bw_valid` and the bus payload hold steady until `bw_ready` is high. A request that needs a bus write is not accepted while a bus write is still held.
- R12: After reset, `act_valid`, `bw_valid` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | CPU request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | WORD_BYTES | Write byte enables |
| req_wdata | input | 8*WORD_BYTES | Write data |
| req_attr | input | 8 | Region attribute byte |
| req_hit | input | 1 | Cache lookup hit |
| flush_in | input | 1 | Pulse: flush the combine buffer |
| ws_limit | input | LIM_W | Cap on outstanding bus writes for serialized regions |
| err_clr | input | 1 | Pulse: clear the sticky error |
| act_valid | output | 1 | Decision outputs valid |
| act_rd_hit | output | 1 | Read served from cache |
| act_fill | output | 1 | Read miss allocates a line |
| act_bus_rd | output | 1 | Read goes to the bus |
| act_upd | output | 1 | Write updates the cache line |
| act_dirty | output | 1 | Line marked dirty |
| act_alloc | output | 1 | Write miss allocates a line |
| bw_valid | output | 1 | Bus write offered |
| bw_ready | input | 1 | Bus write taken |
| bw_line | output | ADDR_W-OFF_W | Line address of bus write |
| bw_data | output | 8*LINE_BYTES | Line-wide write data |
| bw_be | output | LINE_BYTES | Byte mask of bus write |
| bw_done | input | 1 | One bus write completed |
| err_flag | output | 1 | Sticky undefined-attribute error |

## Verification
Checked on every cycle: the bus port holds its payload while stalled, a serialized write is never accepted with the count at its cap, an undefined access always leaves the error flag set and no cache action, protected writes cause no action, and write-through never marks a line dirty or allocates. Only the bench's scenarios can show several things. One is the content and order of the bus writes, including merged combine lines where the last value wins. Others are the correct flush ahead of each kind of trigger, the full decision table across attribute values, and the release of a stalled serialized write once completions arrive.

// File: rtl/rgn_pkg.sv
package rgn_pkg;
  localparam int A_CD = 0;
  localparam int A_WA = 1;
  localparam int A_WP = 2;
  localparam int A_WT = 3;
  localparam int A_WC = 4;
  localparam int A_WS = 5;

  typedef struct packed {
    logic err;
    logic rd_hit;
    logic fill;
    logic bus_rd;
    logic upd;
    logic dirty;
    logic alloc;
    logic bus_wr;
    logic comb;
    logic ser;
  } rgn_dec_t;
endpackage

// File: rtl/rgn_attr_decode.sv
module rgn_attr_decode
  import rgn_pkg::*;
(
  input  logic [7:0] attr,
  input  logic       is_wr,
  input  logic       hit,
  output rgn_dec_t   d
);
  logic cd, wa, wp, wt, wc, ws;
  assign cd = attr[A_CD];
  assign wa = attr[A_WA];
  assign wp = attr[A_WP];
  assign wt = attr[A_WT];
  assign wc = attr[A_WC];
  assign ws = attr[A_WS];

  always_comb begin
    d = '0;
    if (!is_wr) begin
      if (ws && !cd) begin
        d.err = 1'b1;
      end else begin
        d.rd_hit = hit;
        d.fill   = !hit && !cd;
        d.bus_rd = !hit && cd;
      end
    end else if (wp) begin
      d = '0;
    end else if (((ws || wc) && !cd) || (wa && cd)) begin
      d.err = 1'b1;
    end else if (cd) begin
      d.upd    = hit;
      d.comb   = wc;
      d.bus_wr = !wc;
      d.ser    = ws && !wc;
    end else if (wt) begin
      d.upd    = hit;
      d.bus_wr = 1'b1;
    end else if (hit) begin
      d.upd   = 1'b1;
      d.dirty = 1'b1;
    end else if (wa) begin
      d.alloc = 1'b1;
    end else begin
      d.bus_wr = 1'b1;
    end
  end
endmodule

// File: rtl/rgn_comb_buf.sv
module rgn_comb_buf #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int BYTE_W = $clog2(WORD_BYTES),
  localparam int WOFF_W = OFF_W - BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      merge,
  input  logic                      clear,
  input  logic [ADDR_W-OFF_W-1:0]   line_in,
  input  logic [WOFF_W-1:0]         word_in,
  input  logic [WORD_BYTES-1:0]     be_in,
  input  logic [8*WORD_BYTES-1:0]   wdata_in,
  output logic                      any,
  output logic [ADDR_W-OFF_W-1:0]   line_q,
  output logic [8*LINE_BYTES-1:0]   data_q,
  output logic [LINE_BYTES-1:0]     be_q
);
  assign any = |be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     line_q <= '0;
    else if (merge) line_q <= line_in;
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    localparam int WIDX = b / WORD_BYTES;
    localparam int BIDX = b % WORD_BYTES;
    logic       wr_b;
    logic       v_r;
    logic [7:0] d_r;

    assign wr_b = merge && (int'(word_in) == WIDX) && be_in[BIDX];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     v_r <= 1'b0;
      else if (clear) v_r <= 1'b0;
      else if (wr_b)  v_r <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_b) d_r <= wdata_in[BIDX*8 +: 8];
    end

    assign be_q[b]          = v_r;
    assign data_q[b*8 +: 8] = d_r;
  end
endmodule

// File: rtl/rgn_wr_limiter.sv
module rgn_wr_limiter #(
  parameter int LIM_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic [LIM_W-1:0] limit,
  output logic             room
);
  logic [CNT_W-1:0] cnt;
  logic [LIM_W-1:0] lim_eff;
  logic             dec_ok;
  logic             inc_ok;

  assign lim_eff = (limit == '0) ? LIM_W'(1) : limit;
  assign dec_ok  = dec && (cnt != '0);
  assign inc_ok  = inc && (cnt != {CNT_W{1'b1}});
  assign room    = cnt < CNT_W'(lim_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else begin
      case ({inc_ok, dec_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rgn_policy_engine.sv
module rgn_policy_engine
  import rgn_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int LIM_W      = 3,
  parameter int CNT_W      = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int BYTE_W = $clog2(WORD_BYTES),
  localparam int WOFF_W = OFF_W - BYTE_W,
  localparam int LANES  = LINE_BYTES / WORD_BYTES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_BYTES-1:0]   req_be,
  input  logic [8*WORD_BYTES-1:0] req_wdata,
  input  logic [7:0]              req_attr,
  input  logic                    req_hit,
  input  logic                    flush_in,
  input  logic [LIM_W-1:0]        ws_limit,
  input  logic                    err_clr,
  output logic                    act_valid,
  output logic                    act_rd_hit,
  output logic                    act_fill,
  output logic                    act_bus_rd,
  output logic                    act_upd,
  output logic                    act_dirty,
  output logic                    act_alloc,
  output logic                    bw_valid,
  input  logic                    bw_ready,
  output logic [ADDR_W-OFF_W-1:0] bw_line,
  output logic [8*LINE_BYTES-1:0] bw_data,
  output logic [LINE_BYTES-1:0]   bw_be,
  input  logic                    bw_done,
  output logic                    err_flag
);
  rgn_dec_t dec;

  logic [ADDR_W-OFF_W-1:0] req_line;
  logic [WOFF_W-1:0]       req_word;
  logic                    cb_any;
  logic [ADDR_W-OFF_W-1:0] cb_line;
  logic [8*LINE_BYTES-1:0] cb_data;
  logic [LINE_BYTES-1:0]   cb_be;
  logic                    flush_pend;
  logic                    same_line;
  logic                    flush_for_req;
  logic                    hold;
  logic                    do_flush;
  logic                    room;
  logic                    acc;
  logic [LINE_BYTES-1:0]   one_be;

  assign req_line = req_addr[ADDR_W-1:OFF_W];
  assign req_word = req_addr[OFF_W-1:BYTE_W];

  rgn_attr_decode u_dec (
    .attr  (req_attr),
    .is_wr (req_write),
    .hit   (req_hit),
    .d     (dec)
  );

  assign same_line     = cb_any && (cb_line == req_line);
  assign flush_for_req = req_valid && cb_any && !(dec.comb && same_line);
  assign hold          = cb_any && (flush_pend || flush_for_req);
  assign do_flush      = hold && !bw_valid;

  assign req_ready = !hold &&
                     (!dec.bus_wr || (!bw_valid && (!dec.ser || room)));
  assign acc       = req_valid && req_ready;

  rgn_comb_buf #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .WORD_BYTES (WORD_BYTES)
  ) u_cb (
    .clk      (clk),
    .rst_n    (rst_n),
    .merge    (acc && dec.comb),
    .clear    (do_flush),
    .line_in  (req_line),
    .word_in  (req_word),
    .be_in    (req_be),
    .wdata_in (req_wdata),
    .any      (cb_any),
    .line_q   (cb_line),
    .data_q   (cb_data),
    .be_q     (cb_be)
  );

  rgn_wr_limiter #(
    .LIM_W (LIM_W),
    .CNT_W (CNT_W)
  ) u_lim (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (bw_valid && bw_ready),
    .dec   (bw_done),
    .limit (ws_limit),
    .room  (room)
  );

  assign one_be = {{(LINE_BYTES-WORD_BYTES){1'b0}}, req_be} << {req_word, {BYTE_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_pend <= 1'b0;
    else        flush_pend <= flush_in || (flush_pend && cb_any && !do_flush);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bw_valid <= 1'b0;
      bw_line  <= '0;
      bw_data  <= '0;
      bw_be    <= '0;
    end else if (do_flush) begin
      bw_valid <= 1'b1;
      bw_line  <= cb_line;
      bw_data  <= cb_data;
      bw_be    <= cb_be;
    end else if (acc && dec.bus_wr) begin
      bw_valid <= 1'b1;
      bw_line  <= req_line;
      bw_data  <= {LANES{req_wdata}};
      bw_be    <= one_be;
    end else if (bw_ready) begin
      bw_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid  <= 1'b0;
      act_rd_hit <= 1'b0;
      act_fill   <= 1'b0;
      act_bus_rd <= 1'b0;
      act_upd    <= 1'b0;
      act_dirty  <= 1'b0;
      act_alloc  <= 1'b0;
    end else begin
      act_valid  <= acc;
      act_rd_hit <= acc && dec.rd_hit;
      act_fill   <= acc && dec.fill;
      act_bus_rd <= acc && dec.bus_rd;
      act_upd    <= acc && dec.upd;
      act_dirty  <= acc && dec.dirty;
      act_alloc  <= acc && dec.alloc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                err_flag <= 1'b0;
    else if (acc && dec.err)   err_flag <= 1'b1;
    else if (err_clr)          err_flag <= 1'b0;
  end
endmodule

// File: rtl/rgn_policy_chk.sv
module rgn_policy_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int LIM_W      = 3,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_write,
  input logic [7:0]              req_attr,
  input logic [LIM_W-1:0]        ws_limit,
  input logic                    act_valid,
  input logic                    act_fill,
  input logic                    act_bus_rd,
  input logic                    act_upd,
  input logic                    act_dirty,
  input logic                    act_alloc,
  input logic                    bw_valid,
  input logic                    bw_ready,
  input logic [ADDR_W-OFF_W-1:0] bw_line,
  input logic [8*LINE_BYTES-1:0] bw_data,
  input logic [LINE_BYTES-1:0]   bw_be,
  input logic                    bw_done,
  input logic                    err_flag
);
  logic [7:0]       inflight;
  logic [LIM_W-1:0] cap;
  logic             taken;
  logic             undef;
  logic             ws_wr;
  logic             wp_wr;
  logic             wt_wr;

  assign taken = req_valid && req_ready;
  assign cap   = (ws_limit == '0) ? LIM_W'(1) : ws_limit;
  assign undef = req_write
    ? (!req_attr[2] && (((req_attr[5] || req_attr[4]) && !req_attr[0]) || (req_attr[1] && req_attr[0])))
    : (req_attr[5] && !req_attr[0]);
  assign ws_wr = req_write && req_attr[5] && req_attr[0] && !req_attr[4] && !req_attr[2] && !req_attr[1];
  assign wp_wr = req_write && req_attr[2];
  assign wt_wr = req_write && req_attr[3] && !req_attr[0] && !req_attr[2] &&
                 !req_attr[4] && !req_attr[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 8'(bw_valid && bw_ready) - 8'(bw_done && inflight != 0);
  end

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bw_valid && !bw_ready |=> bw_valid && $stable(bw_line) && $stable(bw_be) && $stable(bw_data));

  // R8
  ws_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && ws_wr |-> inflight < 8'(cap));

  // R3
  undef_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && undef |=> err_flag && !act_upd && !act_fill && !act_alloc && !act_bus_rd && !act_dirty);

  // R4
  wp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && wp_wr |=> act_valid && !act_upd && !act_dirty && !act_alloc);

  // R6
  wt_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && wt_wr |=> !act_dirty && !act_alloc);
endmodule

bind rgn_policy_engine rgn_policy_chk #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES),
  .WORD_BYTES (WORD_BYTES),
  .LIM_W      (LIM_W)
) u_chk (.*);

// File: tb/sim_rgn_policy_engine.sv
module sim_rgn_policy_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [3:0]   req_be = '0;
  logic [31:0]  req_wdata = '0;
  logic [7:0]   req_attr = '0;
  logic         req_hit = 1'b0;
  logic         flush_in = 1'b0;
  logic [2:0]   ws_limit = 3'd2;
  logic         err_clr = 1'b0;
  logic         act_valid, act_rd_hit, act_fill, act_bus_rd, act_upd, act_dirty, act_alloc;
  logic         bw_valid;
  logic         bw_ready = 1'b0;
  logic [26:0]  bw_line;
  logic [255:0] bw_data;
  logic [31:0]  bw_be;
  logic         bw_done = 1'b0;
  logic         err_flag;

  int checks = 0;
  int errors = 0;

  logic [26:0]  q_line [256];
  logic [255:0] q_data [256];
  logic [31:0]  q_be   [256];
  int qh = 0;
  int qt = 0;

  logic         m_any = 1'b0;
  logic [26:0]  m_line = '0;
  logic [255:0] m_data = '0;
  logic [31:0]  m_be = '0;
  logic         m_err = 1'b0;

  int  pend = 0;
  bit  done_en = 1'b1;
  bit  rdy_force = 1'b0;

  always #10 clk = ~clk;

  rgn_policy_engine u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {cls[1:0], err, rd_hit, fill, bus_rd, upd, dirty, alloc}; cls 1 = one bus write, 2 = combine
  function automatic logic [8:0] ref_act(input logic [7:0] a, input logic w, input logic h);
    logic [1:0] cls = 2'd0;
    logic e = 0, rh = 0, fl = 0, br = 0, up = 0, dt = 0, al = 0;
    if (!w) begin
      if (a[5] && !a[0]) e = 1;
      else begin rh = h; fl = !h && !a[0]; br = !h && a[0]; end
    end else if (a[2]) begin
      cls = 0;
    end else if (((a[5] || a[4]) && !a[0]) || (a[1] && a[0])) begin
      e = 1;
    end else if (a[0]) begin
      up = h; cls = a[4] ? 2'd2 : 2'd1;
    end else if (a[3]) begin
      up = h; cls = 1;
    end else if (h) begin
      up = 1; dt = 1;
    end else if (a[1]) begin
      al = 1;
    end else begin
      cls = 1;
    end
    return {cls, e, rh, fl, br, up, dt, al};
  endfunction

  task automatic push(input logic [26:0] l, input logic [255:0] d, input logic [31:0] b);
    q_line[qt % 256] = l;
    q_data[qt % 256] = d;
    q_be[qt % 256]   = b;
    qt++;
  endtask

  task automatic model_flush();
    if (m_any) begin
      push(m_line, m_data, m_be);
      m_any = 0;
      m_be  = '0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_en && pend > 0 && ($urandom % 2 == 0)) begin
        bw_done = 1'b1;
        pend--;
      end else begin
        bw_done = 1'b0;
      end
      bw_ready = rdy_force ? 1'b1 : ($urandom % 4 != 0);
      if (bw_valid && bw_ready) begin
        pend++;
        if (qh == qt) begin
          chk(0, "R7/R9 unexpected bus write", {37'd0, bw_line}, 64'd0);
        end else begin
          logic [255:0] mask;
          for (int i = 0; i < 32; i++) mask[i*8 +: 8] = {8{q_be[qh % 256][i]}};
          chk(bw_line == q_line[qh % 256], "R7 bus line", {37'd0, bw_line}, {37'd0, q_line[qh % 256]});
          chk(bw_be == q_be[qh % 256], "R9 bus mask", {32'd0, bw_be}, {32'd0, q_be[qh % 256]});
          chk((bw_data & mask) == (q_data[qh % 256] & mask), "R9 bus data",
              64'(bw_data & mask), 64'(q_data[qh % 256] & mask));
          qh++;
        end
      end
    end
  end

  task automatic send(input logic w, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] d, input logic [7:0] at, input logic h, input string tag);
    logic [8:0] r;
    int n;
    r = ref_act(at, w, h);
    @(negedge clk);
    req_write = w; req_addr = a; req_be = be; req_wdata = d; req_attr = at; req_hit = h;
    req_valid = 1'b1;
    if (m_any && !(r[8:7] == 2'd2 && m_line == a[31:5])) model_flush();
    n = 0;
    #1;
    while (!req_ready && n < 2000) begin @(negedge clk); #1; n++; end
    if (!req_ready) chk(0, {tag, " request never accepted"}, 0, 1);
    if (r[8:7] == 2'd1) push(a[31:5], {8{d}}, 32'(be) << (a[4:2] * 4));
    if (r[8:7] == 2'd2) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) begin
          m_data[(a[4:2]*4 + b)*8 +: 8] = d[b*8 +: 8];
          m_be[a[4:2]*4 + b] = 1'b1;
        end
      m_line = a[31:5];
      m_any  = |m_be;
    end
    if (r[6]) m_err = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(act_valid == 1'b1, {tag, " act_valid"}, 64'(act_valid), 1);
    chk({act_rd_hit, act_fill, act_bus_rd, act_upd, act_dirty, act_alloc} == r[5:0],
        {tag, " actions"}, 64'({act_rd_hit, act_fill, act_bus_rd, act_upd, act_dirty, act_alloc}), 64'(r[5:0]));
    chk(err_flag == m_err, {tag, " err_flag"}, 64'(err_flag), 64'(m_err));
  endtask

  task automatic do_flush_in();
    @(negedge clk);
    flush_in = 1'b1;
    model_flush();
    @(negedge clk);
    flush_in = 1'b0;
  endtask

  task automatic do_err_clr();
    @(negedge clk);
    err_clr = 1'b1;
    m_err = 1'b0;
    @(negedge clk);
    err_clr = 1'b0;
    chk(err_flag == 1'b0, "R3 err_clr", 64'(err_flag), 0);
  endtask

  task automatic drain();
    int n = 0;
    while ((qh != qt || pend != 0 || bw_valid) && n < 5000) begin @(negedge clk); n++; end
    chk(qh == qt, "R10 expected bus writes drained", qt - qh, 0);
  endtask

  task automatic ws_probe(input logic [2:0] lim, input int pre);
    drain();
    done_en = 0; rdy_force = 1; ws_limit = lim;
    for (int i = 0; i < pre; i++)
      send(1, 32'h0000_2000 + 32'(i*4), 4'hF, 32'hA000_0000 + i, 8'h21, 0, "R8 ws fill");
    fork
      send(1, 32'h0000_2010, 4'hF, 32'hB0B0_B0B0, 8'h21, 0, "R8 ws stalled");
      begin
        repeat (4) @(negedge clk);
        #2;
        chk(req_ready == 1'b0, "R8 ws cap holds ready low", 64'(req_ready), 0);
        done_en = 1;
      end
    join
    rdy_force = 0;
    drain();
  endtask

  localparam logic [7:0] ATTRS [12] = '{8'h00, 8'h02, 8'h08, 8'h0A, 8'h01, 8'h21,
                                        8'h11, 8'h04, 8'h20, 8'h10, 8'h03, 8'hC8};

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(act_valid == 0 && bw_valid == 0 && err_flag == 0, "R12 reset state",
        64'({act_valid, bw_valid, err_flag}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(0, 32'h100, 4'h0, 0, 8'h00, 1, "R1 read hit cacheable");
    send(0, 32'h100, 4'h0, 0, 8'h01, 1, "R1 read hit uncached");
    send(0, 32'h100, 4'h0, 0, 8'h00, 0, "R2 read miss fill");
    send(0, 32'h100, 4'h0, 0, 8'h01, 0, "R2 read miss bus");
    send(0, 32'h100, 4'h0, 0, 8'h20, 0, "R3 read undefined");
    send(0, 32'h100, 4'h0, 0, 8'h00, 1, "R3 err sticky");
    do_err_clr();
    send(1, 32'h104, 4'hF, 32'h1111_1111, 8'h04, 1, "R4 wp hit");
    send(1, 32'h104, 4'hF, 32'h1111_1111, 8'h05, 0, "R4 wp uncached");
    send(1, 32'h108, 4'hF, 32'h2222_2222, 8'h00, 1, "R5 wb hit");
    send(1, 32'h108, 4'h3, 32'h3333_3333, 8'h00, 0, "R5 wb miss");
    send(1, 32'h10C, 4'hF, 32'h4444_4444, 8'h02, 0, "R5 wb alloc");
    send(1, 32'h110, 4'hF, 32'h5555_5555, 8'h08, 1, "R6 wt hit");
    send(1, 32'h114, 4'hC, 32'h6666_6666, 8'h0A, 0, "R6 wt miss");
    send(1, 32'h118, 4'hC, 32'h6767_6767, 8'hC8, 0, "R1 reserved ignored");
    send(1, 32'h200, 4'h1, 32'h0000_0071, 8'h01, 0, "R7 uc 1");
    send(1, 32'h21C, 4'h8, 32'h7200_0000, 8'h01, 1, "R7 uc 2");
    send(1, 32'h300, 4'hF, 32'h7373_7373, 8'h01, 0, "R7 uc 3");
    send(1, 32'h400, 4'hF, 32'hAAAA_AAAA, 8'h11, 0, "R9 wc a");
    send(1, 32'h400, 4'h2, 32'h0000_BB00, 8'h11, 1, "R9 wc overwrite");
    send(1, 32'h414, 4'h9, 32'hCC00_00CC, 8'h11, 0, "R9 wc other word");
    do_flush_in();
    send(1, 32'h420, 4'hF, 32'hDDDD_DDDD, 8'h11, 0, "R10 wc line a");
    send(1, 32'h440, 4'hF, 32'hEEEE_EEEE, 8'h11, 0, "R10 wc line b");
    send(0, 32'h440, 4'h0, 0, 8'h01, 0, "R10 read flushes");
    send(1, 32'h460, 4'h3, 32'h0000_1234, 8'h11, 0, "R10 wc before uc");
    send(1, 32'h480, 4'hF, 32'h5678_5678, 8'h01, 0, "R10 uc after wc");
    send(1, 32'h500, 4'hF, 0, 8'h10, 0, "R3 wc cached undefined");
    send(1, 32'h500, 4'hF, 0, 8'h20, 0, "R3 ws cached undefined");
    do_err_clr();
    send(1, 32'h500, 4'hF, 0, 8'h03, 1, "R3 wa uncached undefined");
    do_err_clr();
    ws_probe(3'd2, 2);
    ws_probe(3'd0, 1);

    for (int i = 0; i < 500; i++) begin
      int r = $urandom % 24;
      if (r == 0) do_flush_in();
      else if (r == 1) do_err_clr();
      else begin
        logic [7:0]  at = ATTRS[$urandom % 12];
        logic [31:0] a  = {25'h40 + 25'($urandom % 2), 3'($urandom % 8), 2'b00} ;
        logic [3:0]  be = 4'($urandom % 15 + 1);
        ws_limit = 3'($urandom % 8);
        send($urandom % 3 != 0, a, be, $urandom, at, $urandom % 2 == 1, "R11 random mix");
      end
    end
    do_flush_in();
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule